// File: doc/BRIEF.md
# Microcoded Datapath ALU

This block is the arithmetic unit of a microcoded 32-bit integer core. It sits on the core's internal bus and holds two operand registers. Each register takes the bus value at a clock edge when its own strobe in the current microword is set. A four-bit function field in the same microword selects what the unit computes from the two registers. When the microword's result-read strobe is set, the unit drives the result onto the bus.

It covers the base integer operations: add, subtract, the three bitwise logic operations, three shifts, and signed and unsigned set-less-than. It also has three operations that the microcode needs for its own work. The first adds four to operand A whatever B holds, and the microcode uses it to step the program counter. The other two sign-extend the low byte or the low halfword of operand A, which completes signed loads.

The result is combinational from the registered operands and the current function field. A microword can therefore load operands in one step and read the result in the next.

Top module: `uc_alu`

## Requirements
- R1: After reset both operand registers hold zero, so with read set and function add the bus output is 0.
- R2: When microword bit 8 is set, operand A takes `busIn` at the clock edge. When bit 8 is clear, operand A keeps its value whatever `busIn` carries.
- R3: When microword bit 9 is set, operand B takes `busIn` at the clock edge. When bit 9 is clear, operand B keeps its value.
- R4: When microword bit 10 is set, `busDrive` is 1 and `busOut` carries the result. When bit 10 is clear, `busDrive` is 0 and `busOut` is all zeros.
- R5: The function is microword bits 14:11, coded as: 0 add-four, 1 add, 2 subtract, 3 or, 4 and, 5 xor, 6 shift left, 7 logical shift right, 8 arithmetic shift right, 9 signed less-than, 10 unsigned less-than, 11 byte sign-extend, 12 halfword sign-extend.
- R6: Function 0 gives operand A plus 4 modulo 2^32, and operand B has no effect on it.
- R7: Add gives A+B and subtract gives A−B, both wrapping modulo 2^32.
- R8: Or, and and xor act bit by bit on A and B.
- R9: All three shifts move A by the amount in B[4:0] and ignore the upper bits of B. Arithmetic shift right fills the vacated bits with A[31].
- R10: The two less-than functions give 1 in bit 0 when A < B, compared signed or unsigned as the function names, and 0 otherwise. Bits 31:1 are always zero.
- R11: Byte sign-extend gives A[7:0] with bit 7 copied into bits 31:8. Halfword sign-extend gives A[15:0] with bit 15 copied into bits 31:16.
- R12: Function codes 13, 14 and 15 give zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| microWord | input | 32 | Current microinstruction |
| busIn | input | 32 | Internal bus value offered to the operand registers |
| busOut | output | 32 | Result onto the bus, zero when not reading |
| busDrive | output | 1 | High while the unit drives the bus |

## Verification
The bench targets places where a small decode slip still gives plausible numbers.

- **Shift amount.** A shift amount with bit 5 set catches a unit that uses more than five bits of B. Such a unit returns zero instead of the shifted value.
- **Signed versus unsigned.** Pairs of −1 and 1 tell the two compares apart: swapping signedness flips the flag. Shifting a negative value tells the arithmetic shift from the logical one.
- **Sign extension.** Values just on either side of the byte and halfword sign bits show whether the extension copies the correct bit.
- **Add-four.** Running it with a large B exposes a unit that adds B.
- **Held operands and quiet bus.** A cycle with a changed bus but no write strobe, and a cycle with read clear, catch operands that load without a strobe and a bus that is driven without a read.

// File: rtl/uc_alu_pkg.sv
package uc_alu_pkg;

  typedef enum logic [3:0] {
    FN_ADD4  = 4'd0,
    FN_ADD   = 4'd1,
    FN_SUB   = 4'd2,
    FN_OR    = 4'd3,
    FN_AND   = 4'd4,
    FN_XOR   = 4'd5,
    FN_SHL   = 4'd6,
    FN_SHRL  = 4'd7,
    FN_SHRA  = 4'd8,
    FN_LTS   = 4'd9,
    FN_LTU   = 4'd10,
    FN_SEXTB = 4'd11,
    FN_SEXTH = 4'd12,
    FN_RSV13 = 4'd13,
    FN_RSV14 = 4'd14,
    FN_RSV15 = 4'd15
  } aluFn_e;

  typedef struct packed {
    logic   loadA;
    logic   loadB;
    logic   readOut;
    aluFn_e fn;
  } aluStrobes_t;

endpackage

// File: rtl/uc_alu_ctrl.sv
module uc_alu_ctrl
  import uc_alu_pkg::*;
#(
  parameter int UW_W     = 32,
  parameter int LOADA_BIT = 8,
  parameter int LOADB_BIT = 9,
  parameter int READ_BIT  = 10,
  parameter int FN_LSB    = 11,
  parameter int FN_W      = 4
) (
  input  logic [UW_W-1:0] microWord,
  output aluStrobes_t     strobes
);

  localparam int FN_MSB = FN_LSB + FN_W - 1;

  always_comb begin
    strobes.loadA   = microWord[LOADA_BIT];
    strobes.loadB   = microWord[LOADB_BIT];
    strobes.readOut = microWord[READ_BIT];
    strobes.fn      = aluFn_e'(microWord[FN_MSB:FN_LSB]);
  end

endmodule

// File: rtl/uc_alu_dp.sv
module uc_alu_dp
  import uc_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  aluStrobes_t       strobes,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  output logic              busDrive
);

  localparam int SH_W = $clog2(DATA_W);
  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;

  logic [DATA_W-1:0] opA;
  logic [DATA_W-1:0] opB;
  logic [DATA_W-1:0] result;
  logic [SH_W-1:0]   shAmt;
  logic              ltSigned;
  logic              ltUnsigned;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opA <= '0;
      opB <= '0;
    end else begin
      if (strobes.loadA) opA <= busIn;
      if (strobes.loadB) opB <= busIn;
    end
  end

  assign shAmt      = opB[SH_W-1:0];
  assign ltSigned   = $signed(opA) < $signed(opB);
  assign ltUnsigned = opA < opB;

  always_comb begin
    case (strobes.fn)
      FN_ADD4:  result = opA + DATA_W'(STEP);
      FN_ADD:   result = opA + opB;
      FN_SUB:   result = opA - opB;
      FN_OR:    result = opA | opB;
      FN_AND:   result = opA & opB;
      FN_XOR:   result = opA ^ opB;
      FN_SHL:   result = opA << shAmt;
      FN_SHRL:  result = opA >> shAmt;
      FN_SHRA:  result = DATA_W'($signed(opA) >>> shAmt);
      FN_LTS:   result = {{(DATA_W-1){1'b0}}, ltSigned};
      FN_LTU:   result = {{(DATA_W-1){1'b0}}, ltUnsigned};
      FN_SEXTB: result = {{(DATA_W-BYTE_W){opA[BYTE_W-1]}}, opA[BYTE_W-1:0]};
      FN_SEXTH: result = {{(DATA_W-HALF_W){opA[HALF_W-1]}}, opA[HALF_W-1:0]};
      default:  result = '0;
    endcase
  end

  assign busOut   = strobes.readOut ? result : '0;
  assign busDrive = strobes.readOut;

  // R2: operand A follows its strobe
  a_r2_a_loads: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadA |=> opA == $past(busIn));
  a_r2_a_holds: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadA |=> $stable(opA));
  // R3: operand B follows its strobe
  a_r3_b_loads: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadB |=> opB == $past(busIn));
  a_r3_b_holds: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadB |=> $stable(opB));

endmodule

// File: rtl/uc_alu.sv
module uc_alu
  import uc_alu_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int UW_W      = 32,
  parameter int LOADA_BIT = 8,
  parameter int LOADB_BIT = 9,
  parameter int READ_BIT  = 10,
  parameter int FN_LSB    = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [UW_W-1:0]   microWord,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  output logic              busDrive
);

  localparam int FN_W = 4;
  localparam int FN_MSB = FN_LSB + FN_W - 1;

  aluStrobes_t strobes;

  uc_alu_ctrl #(
    .UW_W(UW_W), .LOADA_BIT(LOADA_BIT), .LOADB_BIT(LOADB_BIT),
    .READ_BIT(READ_BIT), .FN_LSB(FN_LSB), .FN_W(FN_W)
  ) i_ctrl (
    .microWord(microWord),
    .strobes  (strobes)
  );

  uc_alu_dp #(.DATA_W(DATA_W), .STEP(4)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .busIn   (busIn),
    .busOut  (busOut),
    .busDrive(busDrive)
  );

  // R4: nothing on the bus without the read strobe
  a_r4_quiet_bus: assert property (@(posedge clk) disable iff (!rstN)
    !microWord[READ_BIT] |-> (busOut == '0 && !busDrive));
  // R10: compare results use bit 0 only
  a_r10_flag_only: assert property (@(posedge clk) disable iff (!rstN)
    (microWord[READ_BIT] && (microWord[FN_MSB:FN_LSB] == 4'd9 ||
                             microWord[FN_MSB:FN_LSB] == 4'd10))
    |-> busOut[DATA_W-1:1] == '0);
  // R12: reserved codes read as zero
  a_r12_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (microWord[READ_BIT] && microWord[FN_MSB:FN_LSB] >= 4'd13)
    |-> busOut == '0);

endmodule

// File: tb/test_uc_alu.sv
module test_uc_alu;

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] microWord;
  logic [31:0] busIn;
  logic [31:0] busOut;
  logic        busDrive;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #10 clk = ~clk;

  uc_alu i_uc_alu (
    .clk(clk), .rstN(rstN), .microWord(microWord),
    .busIn(busIn), .busOut(busOut), .busDrive(busDrive)
  );

  // {fn[3:0], a[31:0], b[31:0], expected[31:0]}
  localparam int NV = 23;
  localparam logic [99:0] VEC [NV] = '{
    {4'd0,  32'hFFFFFFFE, 32'h12345678, 32'h00000002},
    {4'd1,  32'h7FFFFFFF, 32'h00000001, 32'h80000000},
    {4'd1,  32'hFFFFFFFF, 32'h00000002, 32'h00000001},
    {4'd2,  32'h00000005, 32'h00000007, 32'hFFFFFFFE},
    {4'd3,  32'hF0F00000, 32'h0000FF0F, 32'hF0F0FF0F},
    {4'd4,  32'hFF00FF00, 32'h0FF00FF0, 32'h0F000F00},
    {4'd5,  32'hAAAA5555, 32'hFFFF0000, 32'h55555555},
    {4'd6,  32'h00000001, 32'h00000024, 32'h00000010},
    {4'd6,  32'h80000001, 32'h0000001F, 32'h80000000},
    {4'd7,  32'h80000000, 32'h0000003F, 32'h00000001},
    {4'd8,  32'h80000000, 32'h00000004, 32'hF8000000},
    {4'd8,  32'h40000000, 32'h00000004, 32'h04000000},
    {4'd9,  32'hFFFFFFFF, 32'h00000001, 32'h00000001},
    {4'd9,  32'h00000001, 32'hFFFFFFFF, 32'h00000000},
    {4'd10, 32'h00000001, 32'hFFFFFFFF, 32'h00000001},
    {4'd10, 32'hFFFFFFFF, 32'h00000001, 32'h00000000},
    {4'd9,  32'h00000005, 32'h00000005, 32'h00000000},
    {4'd11, 32'h12345680, 32'hDEADBEEF, 32'hFFFFFF80},
    {4'd11, 32'hFFFFFF7F, 32'h00000000, 32'h0000007F},
    {4'd12, 32'h00008001, 32'h00000000, 32'hFFFF8001},
    {4'd12, 32'hFFFF7FFF, 32'h00000000, 32'h00007FFF},
    {4'd13, 32'h12345678, 32'h00000001, 32'h00000000},
    {4'd15, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000}
  };

  function automatic string reqOf(input logic [3:0] fn);
    case (fn)
      4'd0:                  return "R6";
      4'd1, 4'd2:            return "R7";
      4'd3, 4'd4, 4'd5:      return "R8";
      4'd6, 4'd7, 4'd8:      return "R9";
      4'd9, 4'd10:           return "R10";
      4'd11, 4'd12:          return "R11";
      default:               return "R12";
    endcase
  endfunction

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic loadA(input logic [31:0] v);
    @(negedge clk);
    microWord = 32'h1 << 8;
    busIn     = v;
    @(negedge clk);
    microWord = 32'h0;
    busIn     = 32'hA5A5A5A5;
  endtask

  task automatic loadB(input logic [31:0] v);
    @(negedge clk);
    microWord = 32'h1 << 9;
    busIn     = v;
    @(negedge clk);
    microWord = 32'h0;
    busIn     = 32'h5A5A5A5A;
  endtask

  task automatic readFn(input logic [3:0] fn, output logic [31:0] v, output logic d);
    @(negedge clk);
    microWord = (32'h1 << 10) | (32'(fn) << 11);
    #3;
    v = busOut;
    d = busDrive;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        nChecks++;
        nFails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        finishRun();
      end
    end
  end

  initial begin
    logic [31:0] got;
    logic        drv;
    rstN      = 1'b0;
    microWord = 32'h0;
    busIn     = 32'h0;
    repeat (3) @(posedge clk);
    #3;
    // R4: read clear during reset, bus quiet
    check("R4", busOut, 32'h0);
    check("R4", {31'b0, busDrive}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset operands are zero
    readFn(4'd1, got, drv);
    check("R1", got, 32'h0);
    check("R4", {31'b0, drv}, 32'h1);

    // R5: table of function codes
    for (int i = 0; i < NV; i++) begin
      logic [3:0]  fn;
      logic [31:0] a, b, e;
      {fn, a, b, e} = VEC[i];
      loadA(a);
      loadB(b);
      readFn(fn, got, drv);
      check(reqOf(fn), got, e);
    end

    // R2: operand A holds without its strobe while the bus changes
    loadA(32'h00000100);
    loadB(32'h00000001);
    @(negedge clk);
    microWord = 32'h1 << 9;
    busIn     = 32'h00000003;
    @(negedge clk);
    microWord = 32'h0;
    readFn(4'd1, got, drv);
    check("R2", got, 32'h00000103);

    // R3: operand B holds when only A is written
    @(negedge clk);
    microWord = 32'h1 << 8;
    busIn     = 32'h00000010;
    @(negedge clk);
    microWord = 32'h0;
    readFn(4'd1, got, drv);
    check("R3", got, 32'h00000013);

    // R4: read clear with a live function gives a quiet bus
    @(negedge clk);
    microWord = 32'h1 << 11;
    #3;
    check("R4", busOut, 32'h0);
    check("R4", {31'b0, busDrive}, 32'h0);

    // R6: add-four ignores a changed operand B
    loadB(32'hFFFFFFFF);
    readFn(4'd0, got, drv);
    check("R6", got, 32'h00000014);

    @(negedge clk);
    microWord = 32'h0;
    finishRun();
  end

endmodule